// File: doc/BRIEF.md
# Shock Detect and Buffer Mode Controller

This block sits beside the audio buffer of a shock-proof disc player and decides, every clock, whether incoming audio is being written (fill), writing is paused because the buffer is full (hold), or writing is paused because the pickup has been disturbed (shock). It raises the shock-detected output when a source asks for it. The sources are a host request, a track detector with selectable polarity that is masked during jumps, a rotational-shock indication that can be enabled, and a watchdog that sees a subcode frame pulse fail to arrive.

It does not compute addresses. Instead it drives strobes to a separate pointer unit. One strobe checkpoints the write position at each subcode frame boundary while filling. Another rolls writing back to that checkpoint when hold or shock ends. A third clears both pointers on a flush. It also keeps the sticky full, empty and fill status bits that a host reads.

States and transitions: `RESET` (code 0) moves to `FILL` on the next clock unless bypass is held. `FILL` (1) moves to `SHOCK` on any shock source, or to `HOLD` when the buffer is full. `HOLD` (2) moves to `SHOCK` on a shock source, or back to `FILL` on position-found or on the buffer running empty with echo clear. `SHOCK` (3) moves back to `FILL` on position-found, or on the buffer running empty with echo clear. Flush or bypass sends every active state to `RESET`.

Top module: `shock_mode_ctrl`

## Requirements
- R1: While reset is low the mode is 0 (RESET), `ptr_clear` is 1, and `shock_det`, `wr_en` and every status flag are 0. On the first clock after release the mode becomes 1 (FILL), with `wr_en` and `flag_fill` set.
- R2: With `cmd_shock` high in FILL or HOLD, the next clock enters mode 3 (SHOCK). There `shock_det` is 1 and `wr_en` is 0.
- R3: The track source is active when `track_det` equals `cmd_track_pol` (1 means active high, 0 means active low). It causes SHOCK only while `cmd_jump_busy` is 0.
- R4: `rot_shock` causes SHOCK only while `cmd_rot_en` is 1.
- R5: Once a frame pulse has been seen, a gap of FRAME_TIMEOUT clocks with no further pulse causes SHOCK. This does not happen if the host has read the status while `flag_full` was set and writing has not resumed since.
- R6: In FILL with `buf_full` high, the next clock enters mode 2 (HOLD). There `flag_full` is set, and `flag_fill` and `wr_en` are cleared.
- R7: When a shock source and `buf_full` are present together in FILL, the mode becomes SHOCK and `flag_full` stays 0.
- R8: `ptr_save` pulses with `frame_pulse` only while writing in FILL. It stays 0 on a frame pulse in HOLD or SHOCK.
- R9: `cmd_pos_found` in HOLD or SHOCK pulses `ptr_restore` in that cycle. The next clock returns to FILL with `shock_det` 0.
- R10: `buf_empty` in HOLD or SHOCK sets `flag_empty`. With `cmd_echo` 0 the mode returns to FILL at once, pulsing `ptr_restore`. With `cmd_echo` 1 the mode stays until position-found or flush.
- R11: `cmd_flush` from any active state wins over every shock source. It gives one clock of RESET with `ptr_clear`, then FILL. Holding `bypass` keeps the mode in RESET, and releasing it passes through that same clearing state.
- R12: `flag_fill` is 1 exactly when the following clock writes or a flush was just issued, and is never 1 together with `shock_det`. `status_rd` clears `flag_full` and `flag_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Bypass level; holds the mode in RESET |
| cmd_flush | input | 1 | One-cycle flush command |
| cmd_pos_found | input | 1 | One-cycle position-found command |
| cmd_shock | input | 1 | Host shock request |
| cmd_jump_busy | input | 1 | Masks the track source |
| cmd_track_pol | input | 1 | Active level of `track_det` |
| cmd_rot_en | input | 1 | Enables the rotational source |
| cmd_echo | input | 1 | Keeps replaying when the buffer drains |
| status_rd | input | 1 | One-cycle host read of the status flags |
| track_det | input | 1 | On/off track detector |
| rot_shock | input | 1 | Rotational-shock indication |
| frame_pulse | input | 1 | Subcode frame boundary pulse |
| buf_full | input | 1 | Buffer full level |
| buf_empty | input | 1 | Buffer empty level |
| shock_det | output | 1 | Shock detected |
| wr_en | output | 1 | Buffer write enable |
| ptr_save | output | 1 | Checkpoint the write pointer |
| ptr_restore | output | 1 | Roll the write pointer back to the checkpoint |
| ptr_clear | output | 1 | Clear read and write pointers |
| flag_full | output | 1 | Sticky full status |
| flag_empty | output | 1 | Sticky empty status |
| flag_fill | output | 1 | Fill status |
| mode | output | 2 | Current mode: 0 RESET, 1 FILL, 2 HOLD, 3 SHOCK |

## Verification
A wrong mode register shows on `mode`, `wr_en` and `shock_det` on the clock right after the offending input, so every transition is checked one clock after its cause. A mis-masked detector source or wrong polarity shows as a spurious or missing SHOCK on that same clock. A broken frame watchdog or full acknowledgement shows only after FILL exits the timeout window, so the bench counts through the whole window and checks the mode on both sides of its last clock. Strobe errors are combinational, so they are sampled in the cycle of their cause, before the edge that consumes them.

// File: rtl/shock_mode_pkg.sv
package shock_mode_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_FILL  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SHOCK = 2'd3
    } buf_mode_e;
endpackage

// File: rtl/shock_src_merge.sv
module shock_src_merge (
    input  logic host_req,
    input  logic track_det,
    input  logic track_pol,
    input  logic jump_busy,
    input  logic rot_shock,
    input  logic rot_en,
    input  logic frame_lost,
    input  logic full_acked,
    output logic shock_req
);
    logic track_hit;
    logic rot_hit;
    logic lost_hit;

    always_comb begin
        track_hit = (track_det == track_pol) && !jump_busy;
        rot_hit   = rot_shock && rot_en;
        lost_hit  = frame_lost && !full_acked;
        shock_req = host_req || track_hit || rot_hit || lost_hit;
    end
endmodule

// File: rtl/frame_loss_det.sv
module frame_loss_det #(
    parameter int FRAME_TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic frame_pulse,
    output logic frame_lost
);
    localparam int CNT_W = (FRAME_TIMEOUT > 2) ? $clog2(FRAME_TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TIMEOUT - 1);

    logic             armed;
    logic [CNT_W-1:0] gap_cnt;

    assign frame_lost = armed && (gap_cnt == LAST) && !frame_pulse;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed   <= 1'b0;
            gap_cnt <= '0;
        end else if (frame_pulse) begin
            armed   <= 1'b1;
            gap_cnt <= '0;
        end else if (frame_lost) begin
            gap_cnt <= '0;
        end else if (armed) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mode_flags.sv
module mode_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic status_rd,
    input  logic set_full,
    input  logic set_empty,
    input  logic fill_next,
    input  logic resume,
    output logic flag_full,
    output logic flag_empty,
    output logic flag_fill,
    output logic full_acked
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_full  <= 1'b0;
            flag_empty <= 1'b0;
            flag_fill  <= 1'b0;
            full_acked <= 1'b0;
        end else begin
            flag_fill <= fill_next;

            if (set_full)
                flag_full <= 1'b1;
            else if (status_rd || clr)
                flag_full <= 1'b0;

            if (set_empty)
                flag_empty <= 1'b1;
            else if (status_rd || clr)
                flag_empty <= 1'b0;

            if (clr || resume)
                full_acked <= 1'b0;
            else if (status_rd && flag_full)
                full_acked <= 1'b1;
        end
    end
endmodule

// File: rtl/shock_mode_ctrl.sv
module shock_mode_ctrl
    import shock_mode_pkg::*;
#(
    parameter int FRAME_TIMEOUT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass,
    input  logic       cmd_flush,
    input  logic       cmd_pos_found,
    input  logic       cmd_shock,
    input  logic       cmd_jump_busy,
    input  logic       cmd_track_pol,
    input  logic       cmd_rot_en,
    input  logic       cmd_echo,
    input  logic       status_rd,
    input  logic       track_det,
    input  logic       rot_shock,
    input  logic       frame_pulse,
    input  logic       buf_full,
    input  logic       buf_empty,
    output logic       shock_det,
    output logic       wr_en,
    output logic       ptr_save,
    output logic       ptr_restore,
    output logic       ptr_clear,
    output logic       flag_full,
    output logic       flag_empty,
    output logic       flag_fill,
    output logic [1:0] mode
);
    buf_mode_e state;
    buf_mode_e nxt;

    logic shock_req;
    logic frame_lost;
    logic full_acked;
    logic drained_resume;
    logic in_pause;

    shock_src_merge u_merge (
        .host_req   (cmd_shock),
        .track_det  (track_det),
        .track_pol  (cmd_track_pol),
        .jump_busy  (cmd_jump_busy),
        .rot_shock  (rot_shock),
        .rot_en     (cmd_rot_en),
        .frame_lost (frame_lost),
        .full_acked (full_acked),
        .shock_req  (shock_req)
    );

    frame_loss_det #(
        .FRAME_TIMEOUT (FRAME_TIMEOUT)
    ) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (ptr_clear),
        .frame_pulse (frame_pulse),
        .frame_lost  (frame_lost)
    );

    assign in_pause       = (state == ST_HOLD) || (state == ST_SHOCK);
    assign drained_resume = buf_empty && !cmd_echo;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET: nxt = bypass ? ST_RESET : ST_FILL;
            ST_FILL: begin
                if (bypass || cmd_flush)      nxt = ST_RESET;
                else if (shock_req)           nxt = ST_SHOCK;
                else if (buf_full)            nxt = ST_HOLD;
                else                          nxt = ST_FILL;
            end
            ST_HOLD: begin
                if (bypass || cmd_flush)      nxt = ST_RESET;
                else if (shock_req)           nxt = ST_SHOCK;
                else if (cmd_pos_found)       nxt = ST_FILL;
                else if (drained_resume)      nxt = ST_FILL;
                else                          nxt = ST_HOLD;
            end
            ST_SHOCK: begin
                if (bypass || cmd_flush)      nxt = ST_RESET;
                else if (cmd_pos_found)       nxt = ST_FILL;
                else if (drained_resume)      nxt = ST_FILL;
                else                          nxt = ST_SHOCK;
            end
            default: nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        shock_det   = (state == ST_SHOCK);
        wr_en       = (state == ST_FILL);
        ptr_clear   = (state == ST_RESET);
        ptr_save    = (state == ST_FILL) && frame_pulse && (nxt == ST_FILL);
        ptr_restore = in_pause && (nxt == ST_FILL);
        mode        = state;
    end

    mode_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ptr_clear),
        .status_rd  (status_rd),
        .set_full   ((state == ST_FILL) && (nxt == ST_HOLD)),
        .set_empty  (in_pause && buf_empty),
        .fill_next  ((nxt == ST_FILL) || ((nxt == ST_RESET) && !bypass)),
        .resume     (ptr_restore),
        .flag_full  (flag_full),
        .flag_empty (flag_empty),
        .flag_fill  (flag_fill),
        .full_acked (full_acked)
    );
endmodule

// File: rtl/shock_mode_chk.sv
module shock_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bypass,
    input logic       cmd_flush,
    input logic       cmd_pos_found,
    input logic       cmd_shock,
    input logic       cmd_echo,
    input logic       frame_pulse,
    input logic       buf_full,
    input logic       buf_empty,
    input logic       shock_det,
    input logic       wr_en,
    input logic       ptr_save,
    input logic       ptr_restore,
    input logic       ptr_clear,
    input logic       flag_fill,
    input logic [1:0] mode
);
    p_host_shock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_shock && !cmd_flush && !bypass && !cmd_pos_found && mode != 2'd0) |=> shock_det);

    p_shock_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shock_det |-> !wr_en);

    p_full_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && buf_full && !cmd_flush && !bypass) |=> !wr_en);

    p_save_only_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !wr_en) |-> !ptr_save);

    p_restore_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_restore |=> (wr_en && !shock_det));

    p_echo_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2 || mode == 2'd3) && buf_empty && cmd_echo &&
         !cmd_pos_found && !cmd_flush && !bypass) |=> !wr_en);

    p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_flush && mode != 2'd0) |=> (ptr_clear && !shock_det));

    p_fill_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_fill && shock_det));
endmodule

bind shock_mode_ctrl shock_mode_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bypass        (bypass),
    .cmd_flush     (cmd_flush),
    .cmd_pos_found (cmd_pos_found),
    .cmd_shock     (cmd_shock),
    .cmd_echo      (cmd_echo),
    .frame_pulse   (frame_pulse),
    .buf_full      (buf_full),
    .buf_empty     (buf_empty),
    .shock_det     (shock_det),
    .wr_en         (wr_en),
    .ptr_save      (ptr_save),
    .ptr_restore   (ptr_restore),
    .ptr_clear     (ptr_clear),
    .flag_fill     (flag_fill),
    .mode          (mode)
);

// File: tb/shock_mode_ctrl_bench.sv
module shock_mode_ctrl_bench;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 0, cmd_flush = 0, cmd_pos_found = 0, cmd_shock = 0;
    logic cmd_jump_busy = 0, cmd_track_pol = 1, cmd_rot_en = 0, cmd_echo = 0;
    logic status_rd = 0, track_det = 0, rot_shock = 0, frame_pulse = 0;
    logic buf_full = 0, buf_empty = 0;
    logic shock_det, wr_en, ptr_save, ptr_restore, ptr_clear;
    logic flag_full, flag_empty, flag_fill;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shock_mode_ctrl #(.FRAME_TIMEOUT(TO)) u_shock_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .cmd_flush(cmd_flush),
        .cmd_pos_found(cmd_pos_found), .cmd_shock(cmd_shock),
        .cmd_jump_busy(cmd_jump_busy), .cmd_track_pol(cmd_track_pol),
        .cmd_rot_en(cmd_rot_en), .cmd_echo(cmd_echo), .status_rd(status_rd),
        .track_det(track_det), .rot_shock(rot_shock), .frame_pulse(frame_pulse),
        .buf_full(buf_full), .buf_empty(buf_empty), .shock_det(shock_det),
        .wr_en(wr_en), .ptr_save(ptr_save), .ptr_restore(ptr_restore),
        .ptr_clear(ptr_clear), .flag_full(flag_full), .flag_empty(flag_empty),
        .flag_fill(flag_fill), .mode(mode)
    );

    // {shock, track_det, track_pol, jump_busy, rot_shock, rot_en, expect_shock}
    localparam logic [6:0] VEC [9] = '{
        7'b1_0_1_0_0_0_1,
        7'b0_1_1_0_0_0_1,
        7'b0_0_0_0_0_0_1,
        7'b0_1_0_0_0_0_0,
        7'b0_0_1_0_0_0_0,
        7'b0_1_1_1_0_0_0,
        7'b0_0_1_0_1_1_1,
        7'b0_0_1_0_1_0_0,
        7'b0_0_0_1_0_0_0
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk(mode == 2'd0, "R1 mode in reset", mode, 0);
        chk(ptr_clear && !shock_det && !wr_en, "R1 clear/ssd/wr in reset",
            {ptr_clear, shock_det, wr_en}, 3'b100);
        chk(!flag_full && !flag_empty && !flag_fill, "R1 flags in reset",
            {flag_full, flag_empty, flag_fill}, 0);
        rst_n = 1'b1;
        tick();
        chk(mode == 2'd1 && wr_en && flag_fill, "R1 fill after release",
            {mode, wr_en, flag_fill}, 4'b0111);

        // R2/R3/R4 detector vectors
        for (int i = 0; i < 9; i++) begin
            {cmd_shock, track_det, cmd_track_pol, cmd_jump_busy, rot_shock, cmd_rot_en} = VEC[i][6:1];
            tick();
            chk(mode == (VEC[i][0] ? 2'd3 : 2'd1), $sformatf("R2/R3/R4 vector %0d mode", i),
                mode, VEC[i][0] ? 3 : 1);
            chk(shock_det == VEC[i][0] && wr_en == !VEC[i][0],
                $sformatf("R2 vector %0d ssd", i), shock_det, VEC[i][0]);
            {cmd_shock, track_det, cmd_track_pol, cmd_jump_busy, rot_shock, cmd_rot_en} = 6'b001000;
            cmd_pos_found = 1'b1;
            tick();
            cmd_pos_found = 1'b0;
        end

        // R6 full -> hold
        buf_full = 1'b1;
        tick();
        buf_full = 1'b0;
        chk(mode == 2'd2 && flag_full && !flag_fill && !wr_en, "R6 hold on full",
            {mode, flag_full, flag_fill, wr_en}, 5'b10100);
        // R12 read clears full
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
        chk(!flag_full, "R12 read clears full", flag_full, 0);
        // R8 no save in hold
        frame_pulse = 1'b1;
        #1;
        chk(!ptr_save, "R8 no save in hold", ptr_save, 0);
        tick();
        frame_pulse = 1'b0;
        // R5 acknowledged full suppresses lost-frame shock
        for (int k = 0; k < TO + 2; k++) tick();
        chk(mode == 2'd2, "R5 acked full no shock", mode, 2);
        // R9 restore
        cmd_pos_found = 1'b1;
        #1;
        chk(ptr_restore, "R9 restore strobe", ptr_restore, 1);
        tick();
        cmd_pos_found = 1'b0;
        chk(mode == 2'd1 && !shock_det, "R9 back to fill", mode, 1);
        // R8 save in fill
        frame_pulse = 1'b1;
        #1;
        chk(ptr_save, "R8 save in fill", ptr_save, 1);
        tick();
        frame_pulse = 1'b0;
        // R5 lost frame
        for (int k = 0; k < TO - 1; k++) tick();
        chk(mode == 2'd1, "R5 inside window", mode, 1);
        tick();
        chk(mode == 2'd3 && shock_det, "R5 lost frame shock", mode, 3);
        // R11 flush from shock
        cmd_flush = 1'b1;
        tick();
        cmd_flush = 1'b0;
        chk(mode == 2'd0 && ptr_clear && !shock_det, "R11 flush clears", mode, 0);
        chk(flag_fill, "R12 fill flag on flush", flag_fill, 1);
        tick();
        chk(mode == 2'd1, "R11 fill after flush", mode, 1);

        // R7 shock beats full
        buf_full = 1'b1; cmd_shock = 1'b1;
        tick();
        buf_full = 1'b0; cmd_shock = 1'b0;
        chk(mode == 2'd3 && !flag_full, "R7 shock over full", {mode, flag_full}, 6);
        // R10 echo keeps shock while empty
        cmd_echo = 1'b1; buf_empty = 1'b1;
        tick();
        chk(mode == 2'd3 && flag_empty, "R10 echo holds, empty set", {mode, flag_empty}, 7);
        tick();
        chk(mode == 2'd3, "R10 echo still holds", mode, 3);
        cmd_echo = 1'b0;
        #1;
        chk(ptr_restore, "R10 restore on drain", ptr_restore, 1);
        tick();
        buf_empty = 1'b0;
        chk(mode == 2'd1, "R10 resume without echo", mode, 1);
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
        chk(!flag_empty, "R12 read clears empty", flag_empty, 0);

        // R11 bypass
        bypass = 1'b1;
        tick();
        chk(mode == 2'd0 && !wr_en && !flag_fill, "R11 bypass holds reset", mode, 0);
        tick(); tick();
        chk(mode == 2'd0 && ptr_clear, "R11 bypass stays", mode, 0);
        bypass = 1'b0;
        tick();
        chk(mode == 2'd1, "R11 leave bypass", mode, 1);
        // R11 flush beats shock
        cmd_flush = 1'b1; cmd_shock = 1'b1;
        tick();
        cmd_flush = 1'b0;
        chk(mode == 2'd0, "R11 flush over shock", mode, 0);
        tick();
        chk(mode == 2'd1, "R11 reset goes fill", mode, 1);
        tick();
        chk(mode == 2'd3, "R2 shock after flush", mode, 3);
        cmd_shock = 1'b0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule